// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block is the storage behind a device's type-0 configuration header. A simple request port reaches it: a dword index, a write flag, 32 bits of write data and four byte enables. A read returns its data one cycle later, flagged by a valid strobe. The identity fields, the header type, the capability pointer and the interrupt pin are elaboration constants. The command register and the interrupt line byte are writable. The status register combines live inputs, fixed capability bits and six sticky error flags. Software clears these flags by writing ones to them.

Six base address slots are set up at elaboration. Each slot is a 32-bit memory window, the low half of a 64-bit memory window, an I/O window or unused. The slot that follows a 64-bit window holds the upper 32 address bits. The encoding bits and the address bits below the window size are fixed in hardware. Host software can therefore size a window by writing all ones to it and reading the value back.

Top module: `cfg_hdr_target`

## Requirements
- R1: Reads of dword 0 return {device ID, vendor ID}, dword 2 returns {class code, revision}, dword 3 returns {8'h00, header type, 16'h0000}, and dword 13 returns the capability pointer in bits 7:0. Any dword index without a defined field reads zero.
- R2: The command register is the low half of dword 1. Bits 0–6 and 8–10 are writable. Bit 7 and bits 15:11 always read zero.
- R3: Each byte enable gates its own byte lane on every write. A lane whose enable is low keeps its old value. This covers the command bytes, the status error byte and the BAR bytes.
- R4: Status is the high half of dword 1. Status bit 3 follows the live interrupt input. Bit 4 is set when the capability pointer is nonzero. Bits 10:9 carry the fixed select-timing code (00 fast, 01 medium, 10 slow). Bits 7:5 and 2:0 read zero.
- R5: Status error bits 8 and 11–15 are each set by a one-cycle event input. Writing 1 clears a bit and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: A memory BAR reads 0 in bit 0 and its type in bits 2:1 (00 for 32-bit, 10 for 64-bit). Bit 3 is its prefetch flag. Bits 3:0 ignore writes.
- R7: After all ones are written to an implemented BAR, it reads back with every address bit below the window size at zero.
- R8: An I/O BAR reads 1 in bit 0 and 0 in bit 1. Bits 1:0 ignore writes, and sizing clears the bits below the window size.
- R9: An unused BAR slot reads zero, even after all ones are written to it.
- R10: The slot after a 64-bit memory BAR stores address bits 63:32 with no encoding bits. It also sizes when written with all ones.
- R11: Reset clears the command register, all status error bits, all BAR address bits and the interrupt line.
- R12: A read request produces the valid strobe and its data exactly one cycle later. A write request never raises the valid strobe.
- R13: Dword 15 holds the writable interrupt line in bits 7:0 and the fixed interrupt pin in bits 15:8. Bits 31:16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Dword index within the header |
| acc_wdata | input | 32 | Write data |
| acc_be | input | 4 | Byte enables for a write |
| irq_live | input | 1 | Current interrupt state, shown in status bit 3 |
| err_evt | input | 6 | One-cycle events for status bits {15,14,13,12,11,8} |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cmd_word | output | 16 | Current command register |

## Verification
Two functions can hit the same status error bit in one cycle: an event input setting it and a write-one-to-clear aimed at it. The bench drives a dword-1 write with the bit's clear lane enabled and pulses that bit's event on the same clock edge. It then expects the bit to read back as set. A clear on its own, issued afterwards, must then drop the bit. The same pairing appears among the byte lanes: one write touches the command bytes while its disabled top lane must leave the error flags untouched.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_MEM32 = 2'd1,
    BAR_MEM64 = 2'd2,
    BAR_IO    = 2'd3
  } bar_kind_e;

  // Writable address bits of one slot; lg is log2 of the window size.
  function automatic logic [31:0] bar_wmask(input logic [1:0] kind,
                                            input logic [5:0] lg,
                                            input logic upper);
    logic [63:0] m;
    m = ~((64'd1 << lg) - 64'd1);
    if (upper) return m[63:32];
    case (kind)
      BAR_MEM32, BAR_MEM64: return m[31:0] & 32'hFFFF_FFF0;
      BAR_IO:               return m[31:0] & 32'hFFFF_FFFC;
      default:              return 32'h0;
    endcase
  endfunction

  // Read-only encoding bits of one slot.
  function automatic logic [31:0] bar_enc(input logic [1:0] kind,
                                          input logic pref,
                                          input logic upper);
    if (upper) return 32'h0;
    case (kind)
      BAR_MEM32: return {28'h0, pref, 3'b000};
      BAR_MEM64: return {28'h0, pref, 3'b100};
      BAR_IO:    return 32'h1;
      default:   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
  import cfg_hdr_pkg::*;
#(
  parameter int          NSLOT    = 6,
  parameter logic [11:0] BAR_KIND = 12'h42D,
  parameter logic [35:0] BAR_LOG2 = {6'd8, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
  parameter logic [5:0]  BAR_PREF = 6'b000100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT-1:0]      wr_sel,
  input  logic [31:0]           wdata,
  input  logic [3:0]            be,
  output logic [NSLOT*32-1:0]   rd_vec
);

  logic [31:0] lanes;
  assign lanes = lane_mask(be);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int          PREV  = (i > 0) ? i - 1 : 0;
    localparam logic [1:0]  KIND  = BAR_KIND[2*i +: 2];
    localparam logic        UPPER = (i > 0) && (BAR_KIND[2*PREV +: 2] == BAR_MEM64);
    localparam logic [5:0]  LG    = UPPER ? BAR_LOG2[6*PREV +: 6] : BAR_LOG2[6*i +: 6];
    localparam logic [31:0] WMASK = bar_wmask(KIND, LG, UPPER);
    localparam logic [31:0] ENC   = bar_enc(KIND, BAR_PREF[i], UPPER);

    if (WMASK == 32'h0) begin : g_dead
      assign rd_vec[32*i +: 32] = ENC;
    end else begin : g_live
      logic [31:0] addr_q;
      logic [31:0] upd;
      assign upd = WMASK & lanes;
      always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= 32'h0;
        else if (wr_sel[i]) addr_q <= (addr_q & ~upd) | (wdata & upd);
      end
      assign rd_vec[32*i +: 32] = addr_q | ENC;

      assert_size_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[i] && wdata == 32'hFFFF_FFFF && be == 4'hF)
          |=> (rd_vec[32*i +: 32] == (WMASK | ENC)));
    end
  end

endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status #(
  parameter logic [1:0] DEVSEL_CODE = 2'b01,
  parameter logic       HAS_CAPS    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wd_cmd,
  input  logic [7:0]  wd_stat_hi,
  input  logic [1:0]  be_cmd,
  input  logic        be_stat_hi,
  input  logic        irq_live,
  input  logic [5:0]  err_evt,
  output logic [15:0] cmd_q,
  output logic [15:0] stat_word
);

  localparam logic [15:0] CMD_WMASK = 16'h077F;

  logic [5:0]  err_q;
  logic [5:0]  clr_vec;
  logic [15:0] cmd_upd;

  assign cmd_upd = {{8{be_cmd[1]}}, {8{be_cmd[0]}}} & CMD_WMASK & {16{wr_en}};
  // error flags map to status bits {15,14,13,12,11,8} = stat_hi bits {7..3,0}
  assign clr_vec = {wd_stat_hi[7:3], wd_stat_hi[0]} & {6{wr_en & be_stat_hi}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 16'h0;
      err_q <= 6'h0;
    end else begin
      cmd_q <= (cmd_q & ~cmd_upd) | (wd_cmd & cmd_upd);
      err_q <= (err_q & ~clr_vec) | err_evt;
    end
  end

  assign stat_word = {err_q[5:1], DEVSEL_CODE, err_q[0], 3'b000, HAS_CAPS, irq_live, 3'b000};

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (|be_cmd)) |=> $stable(cmd_q));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be_stat_hi && !(|err_evt)) |=> ((err_q & $past(clr_vec)) == 6'h0));

  assert_lane_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !be_stat_hi) |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/cfg_hdr_target.sv
module cfg_hdr_target
  import cfg_hdr_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID   = 16'h7E21,
  parameter logic [7:0]  REVISION    = 8'h04,
  parameter logic [23:0] CLASS_CODE  = 24'h058000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [7:0]  CAP_PTR     = 8'h00,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [1:0]  DEVSEL_CODE = 2'b01,
  parameter logic [11:0] BAR_KIND    = 12'h42D,
  parameter logic [35:0] BAR_LOG2    = {6'd8, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
  parameter logic [5:0]  BAR_PREF    = 6'b000100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  input  logic [3:0]        acc_be,
  input  logic              irq_live,
  input  logic [5:0]        err_evt,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [15:0]       cmd_word
);

  localparam int NSLOT     = 6;
  localparam int BAR_FIRST = 4;
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CS    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLASS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HDR   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_INT   = ADDR_W'(15);

  logic                 rd_req, wr_req;
  logic [NSLOT-1:0]     bar_wr_sel;
  logic [NSLOT*32-1:0]  bar_rd;
  logic [15:0]          stat_word;
  logic [7:0]           int_line_q;
  logic [31:0]          rd_mux;

  assign rd_req = acc_valid & ~acc_write;
  assign wr_req = acc_valid &  acc_write;

  for (genvar i = 0; i < NSLOT; i++) begin : g_sel
    assign bar_wr_sel[i] = wr_req && (acc_addr == ADDR_W'(BAR_FIRST + i));
  end

  cfg_bar_bank #(
    .NSLOT(NSLOT), .BAR_KIND(BAR_KIND), .BAR_LOG2(BAR_LOG2), .BAR_PREF(BAR_PREF)
  ) bars_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(bar_wr_sel),
    .wdata(acc_wdata), .be(acc_be), .rd_vec(bar_rd)
  );

  cfg_cmd_status #(
    .DEVSEL_CODE(DEVSEL_CODE), .HAS_CAPS(CAP_PTR != 8'h00)
  ) cs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_req && acc_addr == A_CS),
    .wd_cmd(acc_wdata[15:0]), .wd_stat_hi(acc_wdata[31:24]),
    .be_cmd(acc_be[1:0]), .be_stat_hi(acc_be[3]),
    .irq_live(irq_live), .err_evt(err_evt),
    .cmd_q(cmd_word), .stat_word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) int_line_q <= 8'h0;
    else if (wr_req && acc_addr == A_INT && acc_be[0]) int_line_q <= acc_wdata[7:0];
  end

  always_comb begin
    rd_mux = 32'h0;
    case (acc_addr)
      A_ID:    rd_mux = {DEVICE_ID, VENDOR_ID};
      A_CS:    rd_mux = {stat_word, cmd_word};
      A_CLASS: rd_mux = {CLASS_CODE, REVISION};
      A_HDR:   rd_mux = {8'h00, HEADER_TYPE, 16'h0000};
      A_CAP:   rd_mux = {24'h0, CAP_PTR};
      A_INT:   rd_mux = {16'h0, INT_PIN, int_line_q};
      default: begin
        for (int k = 0; k < NSLOT; k++)
          if (acc_addr == ADDR_W'(BAR_FIRST + k)) rd_mux = bar_rd[32*k +: 32];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  assert_read_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_write_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_cmd_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_addr == A_CS) |=> (rd_data[7] == 1'b0 && rd_data[15:11] == 5'h0));

endmodule

// File: tb/cfg_hdr_target_tb_top.sv
module cfg_hdr_target_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = 4'h0;
  logic [31:0] acc_wdata = 32'h0;
  logic [3:0]  acc_be = 4'h0;
  logic        irq_live = 1'b0;
  logic [5:0]  err_evt = 6'h0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] cmd_word;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cfg_hdr_target dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_be(acc_be),
    .irq_live(irq_live), .err_evt(err_evt),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmd_word(cmd_word)
  );

  // window value after sizing: address bits below the size cleared, encoding ORed in
  function automatic logic [31:0] sized(input longint unsigned size, input logic [31:0] enc,
                                        input logic [31:0] keep);
    return ((32'hFFFF_FFFF - 32'(size - 1)) & keep) | enc;
  endfunction

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12: unexpected read strobe, data=%h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic cfg_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_be = 4'h0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk); err_evt = m;
    @(negedge clk); err_evt = 6'h0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 identity
    cfg_rd(4'd0, 32'h7E21_A5C3, "R1 id");
    cfg_rd(4'd2, 32'h0580_0004, "R1 class");
    cfg_rd(4'd3, 32'h0000_0000, "R1 header");
    cfg_rd(4'd13, 32'h0, "R1 cap ptr");
    cfg_rd(4'd12, 32'h0, "R1 reserved dword");
    // R11 reset state, R4 devsel medium
    cfg_rd(4'd1, 32'h0200_0000, "R11 cmd/status reset");
    cfg_rd(4'd4, 32'h0, "R11 BAR0 reset");
    cfg_rd(4'd5, 32'h1, "R8 BAR1 io encoding");
    cfg_rd(4'd6, 32'hC, "R6 BAR2 mem64 prefetch encoding");
    cfg_rd(4'd15, 32'h0000_0100, "R13 int reset");
    // R2 / R3: writes to command lanes only
    cfg_wr(4'd1, 32'hFFFF_FFFF, 4'b0011);
    cfg_rd(4'd1, 32'h0200_077F, "R2 R3 cmd writable mask");
    // R12: write raises no strobe
    @(negedge clk);
    total++;
    if (rd_valid !== 1'b0) begin bad++; $display("FAIL R12: strobe after write got %b expected 0", rd_valid); end
    // R4 live interrupt
    irq_live = 1'b1;
    cfg_rd(4'd1, 32'h0208_077F, "R4 irq live");
    // R5 set by events
    pulse(6'b100001);
    cfg_rd(4'd1, 32'h8308_077F, "R5 event set");
    // R5 w1c only bit 8, cmd untouched (R3)
    cfg_wr(4'd1, 32'h0100_0000, 4'b1000);
    cfg_rd(4'd1, 32'h8208_077F, "R5 R3 w1c bit8");
    // R5 zeros have no effect on error bits; R2 cmd cleared
    cfg_wr(4'd1, 32'h0000_0000, 4'b1111);
    cfg_rd(4'd1, 32'h8208_0000, "R5 write zero ignored");
    // R3: top lane disabled, clear pattern must not apply
    cfg_wr(4'd1, 32'hFFFF_0000, 4'b0111);
    cfg_rd(4'd1, 32'h8208_0000, "R3 status lane gated");
    // R5 set wins over clear in same cycle
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd1; acc_wdata = 32'h8000_0000; acc_be = 4'b1000;
    err_evt = 6'b100000;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_be = 4'h0; err_evt = 6'h0;
    cfg_rd(4'd1, 32'h8208_0000, "R5 set wins");
    cfg_wr(4'd1, 32'h8000_0000, 4'b1000);
    cfg_rd(4'd1, 32'h0208_0000, "R5 clear alone");
    // R7..R10 sizing
    for (int s = 4; s <= 9; s++) cfg_wr(s[3:0], 32'hFFFF_FFFF, 4'hF);
    cfg_rd(4'd4, sized(64'd4096, 32'h0, 32'hFFFF_FFF0), "R7 BAR0 4KiB");
    cfg_rd(4'd5, sized(64'd32, 32'h1, 32'hFFFF_FFFC), "R8 BAR1 io 32");
    cfg_rd(4'd6, sized(64'd1048576, 32'hC, 32'hFFFF_FFF0), "R7 R6 BAR2 1MiB");
    cfg_rd(4'd7, 32'hFFFF_FFFF, "R10 BAR3 upper sizing");
    cfg_rd(4'd8, 32'h0, "R9 BAR4 unused");
    cfg_rd(4'd9, sized(64'd256, 32'h0, 32'hFFFF_FFF0), "R7 BAR5 256");
    // R6 encoding read-only, address bits stored
    cfg_wr(4'd4, 32'h1234_5678, 4'hF);
    cfg_rd(4'd4, 32'h1234_5000, "R6 BAR0 address");
    cfg_wr(4'd6, 32'h0000_0000, 4'hF);
    cfg_rd(4'd6, 32'h0000_000C, "R6 BAR2 encoding fixed");
    cfg_wr(4'd7, 32'hDEAD_BEEF, 4'hF);
    cfg_rd(4'd7, 32'hDEAD_BEEF, "R10 upper address");
    // R3 BAR lane
    cfg_wr(4'd5, 32'h0000_AB00, 4'b0010);
    cfg_rd(4'd5, 32'hFFFF_ABE1, "R3 BAR lane");
    // R13 int line
    cfg_wr(4'd15, 32'h5A5A_5A5A, 4'hF);
    cfg_rd(4'd15, 32'h0000_015A, "R13 int line");
    // R11 second reset
    pulse(6'b000010);
    do_reset();
    cfg_rd(4'd1, 32'h0208_0000, "R11 cmd/err cleared");
    cfg_rd(4'd4, 32'h0, "R11 BAR0 cleared");
    cfg_rd(4'd7, 32'h0, "R11 BAR3 cleared");
    cfg_rd(4'd15, 32'h0000_0100, "R11 int line cleared");
    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R12: %0d reads unanswered expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule